// File: doc/BRIEF.md
# GPIO controller with interrupt detection

A 32-pin general-purpose I/O port controlled through eight 32-bit word registers. Each pin is either an output, driven from a data latch with its enable taken from a direction register, or an input whose pad value passes through a two-flop synchroniser. Every pin carries a 2-bit trigger code that selects low level, high level, rising edge or falling edge. A per-pin both-edges bit overrides that code. A detected condition sets a sticky status bit, which software clears by writing 1 to it.

Status bits are gated by a mask and gathered into two registered interrupt lines: one covers pins 0 to 15 and the other covers pins 16 to 31. The register interface has one write strobe, a byte address, write data and registered read data. Reads have no side effects. All registers, the read data and the interrupt lines are flops, so the block's edge timing is fixed and simple.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the data, direction, both-edges, mask and both trigger registers read 0. pad_out, pad_oe, irq_lo and irq_hi are 0. With all pads low, the default low-level code sets every status bit, so status reads 0xFFFFFFFF.
- R2: Register byte offsets are: data 0x00, direction 0x04, pad status 0x08, trigger low half 0x0C, trigger high half 0x10, mask 0x14, status 0x18, both-edges 0x1C. Only word-aligned accesses decode. pad_out follows the data latch and pad_oe follows the direction register (1 = output) one clock after the write. bus_rdata shows the addressed register one clock after bus_addr is presented.
- R3: A read of data returns the latch bit for output pins and the synchronised pad bit for input pins. A read of pad status returns the synchronised pad value for all pins. Writes to pad status have no effect.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R5: Pin p takes its 2-bit code from bits 2p+1:2p of the low trigger register when p < 16, and from bits 2(p-16)+1:2(p-16) of the high trigger register otherwise. Code 2 (rising) sets status only on a 0-to-1 change.
- R6: Code 3 (falling) sets status only on a 1-to-0 change.
- R7: Code 0 (low level) and code 1 (high level) set status on every clock while the level holds. A clear that coincides with a detection loses to the detection, so a clear only takes effect once the level is gone.
- R8: When a pin's both-edges bit is 1, either edge sets its status, whatever its trigger code says.
- R9: irq_lo is the OR over pins 0 to 15 of status AND mask, and irq_hi is the same over pins 16 to 31. Masked-off pins still record status.
- R10: A pad change on an enabled pin raises its interrupt line on the fourth rising clock edge after the change. A clear of the status bit drops the line on the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the register addressed the cycle before |
| pad_in | input | 32 | Asynchronous pad input values |
| pad_out | output | 32 | Output latch driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
A corrupted status bit shows up within two clocks in two places: it can be read back at offset 0x18, and on an unmasked pin it appears on the interrupt line of its half. A wrong code decode or a wrong half split sets the wrong status bit, or none, within the four-edge detection latency. The bench therefore probes each code at the lowest and the highest register half. A broken synchroniser or edge register shifts the interrupt edge away from the fourth clock, and the bench checks that edge to the exact cycle. It also checks the priority of a level detection over a clear by clearing while the level holds.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS * 4);

  typedef enum logic [2:0] {
    RG_DATA = 3'd0,
    RG_DIR  = 3'd1,
    RG_PAD  = 3'd2,
    RG_TRGL = 3'd3,
    RG_TRGH = 3'd4,
    RG_MASK = 3'd5,
    RG_STAT = 3'd6,
    RG_BOTH = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'd0,
    TRG_HIGH = 2'd1,
    TRG_RISE = 2'd2,
    TRG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_edge_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] prev,
  input  logic [NPIN-1:0] trg_lo,
  input  logic [NPIN-1:0] trg_hi,
  input  logic [NPIN-1:0] both,
  output logic [NPIN-1:0] evt
);
  localparam int HALF = NPIN / 2;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [1:0] code;
    if (p < HALF) begin : g_lo
      assign code = trg_lo[2*p +: 2];
    end else begin : g_hi
      assign code = trg_hi[2*(p-HALF) +: 2];
    end

    always_comb begin
      if (both[p]) begin
        evt[p] = cur[p] ^ prev[p];
      end else begin
        unique case (trig_e'(code))
          TRG_LOW:  evt[p] = ~cur[p];
          TRG_HIGH: evt[p] = cur[p];
          TRG_RISE: evt[p] = cur[p] & ~prev[p];
          TRG_FALL: evt[p] = ~cur[p] & prev[p];
          default:  evt[p] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_wr,
  input  logic [gpio_edge_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]                    bus_wdata,
  output logic [DW-1:0]                    bus_rdata,
  input  logic [DW-1:0]                    pad_in,
  output logic [DW-1:0]                    pad_out,
  output logic [DW-1:0]                    pad_oe,
  output logic                             irq_lo,
  output logic                             irq_hi
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] data_q, dir_q, trgl_q, trgh_q, mask_q, stat_q, both_q;
  logic [DW-1:0] rdata_q;
  logic          irq_lo_q, irq_hi_q;
  logic [DW-1:0] pad_s, pad_p, evt, stat_clr, rd_mux;
  logic          aligned, wr_en;
  reg_sel_e      sel;

  gpio_pad_sync #(.W(DW)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .pad  (pad_in),
    .cur  (pad_s),
    .prev (pad_p)
  );

  gpio_trig_detect #(.NPIN(DW)) i_detect (
    .cur    (pad_s),
    .prev   (pad_p),
    .trg_lo (trgl_q),
    .trg_hi (trgh_q),
    .both   (both_q),
    .evt    (evt)
  );

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign sel      = reg_sel_e'(bus_addr[ADDR_W-1:2]);
  assign wr_en    = bus_wr & aligned;
  assign stat_clr = (wr_en && sel == RG_STAT) ? bus_wdata : '0;

  always_comb begin
    unique case (sel)
      RG_DATA: rd_mux = (data_q & dir_q) | (pad_s & ~dir_q);
      RG_DIR:  rd_mux = dir_q;
      RG_PAD:  rd_mux = pad_s;
      RG_TRGL: rd_mux = trgl_q;
      RG_TRGH: rd_mux = trgh_q;
      RG_MASK: rd_mux = mask_q;
      RG_STAT: rd_mux = stat_q;
      RG_BOTH: rd_mux = both_q;
      default: rd_mux = '0;
    endcase
    if (!aligned) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      dir_q    <= '0;
      trgl_q   <= '0;
      trgh_q   <= '0;
      mask_q   <= '0;
      both_q   <= '0;
      stat_q   <= '0;
      rdata_q  <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          RG_DATA: data_q <= bus_wdata;
          RG_DIR:  dir_q  <= bus_wdata;
          RG_TRGL: trgl_q <= bus_wdata;
          RG_TRGH: trgh_q <= bus_wdata;
          RG_MASK: mask_q <= bus_wdata;
          RG_BOTH: both_q <= bus_wdata;
          default: ;
        endcase
      end
      stat_q   <= (stat_q & ~stat_clr) | evt;
      irq_lo_q <= |(stat_q[HALF-1:0] & mask_q[HALF-1:0]);
      irq_hi_q <= |(stat_q[DW-1:HALF] & mask_q[DW-1:HALF]);
      rdata_q  <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = data_q;
  assign pad_oe    = dir_q;
  assign irq_lo    = irq_lo_q;
  assign irq_hi    = irq_hi_q;

  // R9
  irq_lo_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(|mask_q[HALF-1:0]));

  // R9
  irq_hi_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(|mask_q[DW-1:HALF]));

  // R4
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|stat_clr) |=> ((stat_q & $past(stat_clr & ~evt)) == '0));

  // R7
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R4
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|evt) && !(|stat_clr)) |=> $stable(stat_q));
endmodule

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_DIR  = 5'h04;
  localparam logic [4:0] A_PAD  = 5'h08;
  localparam logic [4:0] A_TRGL = 5'h0C;
  localparam logic [4:0] A_TRGH = 5'h10;
  localparam logic [4:0] A_MASK = 5'h14;
  localparam logic [4:0] A_STAT = 5'h18;
  localparam logic [4:0] A_BOTH = 5'h1C;
  localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

  localparam int K_RD = 0, K_IRQL = 1, K_IRQH = 2, K_POUT = 3, K_POE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    int          due;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  gpio_edge_port i_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int kind, input logic [31:0] e, input int dly, input string req);
    sb_q.push_back('{kind, e, cyc + dly, req});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    expect_at(K_RD, e, 1, req);
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; pad_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 1'b0;
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // monitor: pops scoreboard entries that fall due on this cycle
  always @(negedge clk) begin
    for (int k = sb_q.size() - 1; k >= 0; k--) begin
      if (sb_q[k].due == cyc) begin
        logic [31:0] act;
        case (sb_q[k].kind)
          K_RD:    act = bus_rdata;
          K_IRQL:  act = {31'd0, irq_lo};
          K_IRQH:  act = {31'd0, irq_hi};
          K_POUT:  act = pad_out;
          default: act = pad_oe;
        endcase
        checks++;
        if (act !== sb_q[k].exp) begin
          fails++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                   sb_q[k].req, sb_q[k].kind, cyc, act, sb_q[k].exp);
        end
        sb_q.delete(k);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(A_DATA, 32'h0, "R1 data");
    rd(A_DIR,  32'h0, "R1 dir");
    rd(A_TRGL, 32'h0, "R1 trig low");
    rd(A_TRGH, 32'h0, "R1 trig high");
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_BOTH, 32'h0, "R1 both");
    rd(A_STAT, 32'hFFFF_FFFF, "R1 status low-level default");
    expect_at(K_POUT, 32'h0, 1, "R1 pad_out");
    expect_at(K_POE,  32'h0, 1, "R1 pad_oe");
    expect_at(K_IRQL, 32'h0, 1, "R1 irq_lo");
    expect_at(K_IRQH, 32'h0, 1, "R1 irq_hi");

    // R2 output drive and offsets
    wr(A_DIR, 32'h0000_00FF);
    wr(A_DATA, 32'hA5A5_A5A5);
    expect_at(K_POUT, 32'hA5A5_A5A5, 1, "R2 pad_out");
    expect_at(K_POE,  32'h0000_00FF, 1, "R2 pad_oe");
    rd(A_DIR, 32'h0000_00FF, "R2 dir readback");

    // R3 data read mixing, pad status read-only
    set_pad(32'h1234_5600);
    idle(4);
    rd(A_DATA, 32'h1234_56A5, "R3 data mix");
    rd(A_PAD,  32'h1234_5600, "R3 pad status");
    wr(A_PAD, 32'hFFFF_FFFF);
    rd(A_PAD,  32'h1234_5600, "R3 pad write ignored");
    set_pad(32'h0);
    idle(4);

    // R4 clear all after switching to rising
    wr(A_TRGL, ALL_RISE);
    wr(A_TRGH, ALL_RISE);
    idle(1);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R4 clear all");

    // R5 rising on pins 3 and 20
    set_pad(32'h0010_0008);
    idle(4);
    rd(A_STAT, 32'h0010_0008, "R5 rising both halves");
    set_pad(32'h0);
    idle(4);
    rd(A_STAT, 32'h0010_0008, "R5 falling ignored");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h0010_0008, "R4 write zero no effect");
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, 32'h0010_0000, "R4 partial clear");
    wr(A_STAT, 32'hFFFF_FFFF);

    // R6 falling on pin 5
    wr(A_TRGL, 32'hAAAA_AEAA);
    set_pad(32'h0000_0020);
    idle(4);
    rd(A_STAT, 32'h0, "R6 rising ignored");
    set_pad(32'h0);
    idle(4);
    rd(A_STAT, 32'h0000_0020, "R6 falling detected");
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_TRGL, ALL_RISE);

    // R8 both edges on pin 7
    wr(A_BOTH, 32'h0000_0080);
    set_pad(32'h0000_0080);
    idle(4);
    rd(A_STAT, 32'h0000_0080, "R8 rise");
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, 32'h0, "R8 cleared");
    set_pad(32'h0);
    idle(4);
    rd(A_STAT, 32'h0000_0080, "R8 fall");
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_BOTH, 32'h0);

    // R7 high level on pin 18, clear while held
    wr(A_TRGH, 32'hAAAA_AA9A);
    set_pad(32'h0004_0000);
    idle(4);
    rd(A_STAT, 32'h0004_0000, "R7 high level");
    wr(A_STAT, 32'h0004_0000);
    rd(A_STAT, 32'h0004_0000, "R7 clear loses to level");
    set_pad(32'h0);
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R7 clear after level gone");
    wr(A_TRGH, ALL_RISE);

    // R7 low level on pin 0
    wr(A_TRGL, 32'hAAAA_AAA8);
    idle(2);
    rd(A_STAT, 32'h0000_0001, "R7 low level");
    set_pad(32'h0000_0001);
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R7 low level released");
    wr(A_TRGL, ALL_RISE);
    set_pad(32'h0);
    idle(4);

    // R9 / R10 interrupt routing and latency
    wr(A_MASK, 32'h0200_0004);
    set_pad(32'h0000_0004);
    expect_at(K_IRQL, 32'h0, 3, "R10 irq_lo before fourth edge");
    expect_at(K_IRQL, 32'h1, 4, "R10 irq_lo at fourth edge");
    expect_at(K_IRQH, 32'h0, 4, "R9 irq_hi quiet for low pin");
    idle(5);
    wr(A_STAT, 32'h0000_0004);
    expect_at(K_IRQL, 32'h1, 1, "R10 irq_lo held one edge");
    expect_at(K_IRQL, 32'h0, 2, "R10 irq_lo drops after clear");
    set_pad(32'h0000_0204);
    idle(5);
    rd(A_STAT, 32'h0000_0200, "R9 masked pin records");
    expect_at(K_IRQL, 32'h0, 1, "R9 masked pin no irq");
    set_pad(32'h0200_0204);
    idle(5);
    expect_at(K_IRQH, 32'h1, 1, "R9 irq_hi from pin 25");
    expect_at(K_IRQL, 32'h0, 1, "R9 irq_lo unaffected");
    idle(1);
    wr(A_MASK, 32'h0);
    expect_at(K_IRQH, 32'h0, 2, "R9 mask off drops irq_hi");
    rd(A_STAT, 32'h0200_0200, "R9 status kept while masked");

    idle(6);
    done = 1;
    report();
    $finish;
  end
endmodule